// File: doc/BRIEF.md
# Serial command front end for a quad digital potentiometer

This block sits between a four-wire serial host port and the register logic of a four-channel digital potentiometer. It runs in the system clock domain on chip select, serial clock, serial data in, pause, write-protect and a two-bit address strap, all already synchronised. After each falling edge of chip select it frames the traffic into bytes. First comes an identity byte, which must carry the fixed type code and match the straps. An instruction byte follows, and some commands then take a data byte. The block turns the traffic into commit strobes for the register logic, into single-step pulses for the wiper counters, and into a serial readback of a wiper register, a stored register or a busy flag.

The register logic presents every wiper register value on a flat bus and every stored register value on a second flat bus. The block picks the addressed value itself. A commit is reported only when chip select rises after a frame of exactly the right length. A store into a stored register is refused while write protection is active. A pause input freezes the bit sequence without losing its place.

Top module: `spipot_frontend`

## Requirements
- R1: After reset no frame begins until chip select has been seen high and then low. Traffic clocked while chip select stayed low from reset produces no strobe.
- R2: The first byte of a frame, MSB first, must be 0101 in bits 7..4, 00 in bits 3..2 and equal to `strap` in bits 1..0. On any mismatch the rest of the frame produces no strobe, no step and no enabled output.
- R3: The second byte holds the opcode in bits 7..4, the register select in bits 3..2 and the pot select in bits 1..0. The transfer opcodes need exactly 16 bits, and each reports one `cmd_valid` pulse after chip select rises. Opcode 1101 reports kind 3 (stored to wiper) and 1110 reports kind 4 (wiper to stored). Opcode 0001 reports kind 5 (all stored to wiper) and 1000 reports kind 6 (all wiper to stored). `cmd_pot` and `cmd_reg` carry the selects as sent, and `cmd_data` is 0.
- R4: Opcode 1010 (kind 1, write wiper) and opcode 1100 (kind 2, write stored) need exactly 24 bits. Bits 5..0 of the third byte appear on `cmd_data` with a single `cmd_valid` pulse after chip select rises.
- R5: Opcode 1001 reads wiper register P, and opcode 1011 reads stored register R of pot P. The stored value is taken from `dr_bus[(P*4+R)*6 +: 6]`. The third byte is returned as 00 followed by the 6-bit value, MSB first. Each bit changes on a falling serial clock edge, and `sdo_en` is high for the whole byte.
- R6: The full instruction byte 0101_0001 returns the byte 0000000W, where W is `wip`.
- R7: After opcode 0010, every further rising serial clock edge gives one `step_valid` pulse, with `step_up` equal to the sampled `sdi` and `step_pot` equal to the pot select. This continues until chip select rises.
- R8: Pulling `hold_n` low while the serial clock is low pauses the frame. Serial clock edges are then ignored and `sdo_en` is low. Raising `hold_n` while the serial clock is low resumes the frame at the same bit.
- R9: `sdo_en` is low whenever `cs_n` is high, and it is low out of reset.
- R10: A frame that ends part-way through a byte, or that carries extra bits after its last byte, reports no commit. A final serial clock edge seen in the same cycle as chip select rising does not count.
- R11: An unused opcode, and opcode 0101 with any low nibble other than 0001, is a no-op. It gives no strobe, no step, and `sdo_en` stays low.
- R12: If `wp_n` is low when chip select rises, kinds 2, 4 and 6 are not reported. Kinds 1, 3 and 5 still are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active, synchronised |
| sck | input | 1 | Serial clock, synchronised |
| sdi | input | 1 | Serial data from host |
| hold_n | input | 1 | Pause request, low active |
| wp_n | input | 1 | Write protection, low active |
| strap | input | 2 | Device address straps |
| wcr_bus | input | 24 | Wiper register values, pot p at bits p*6 +: 6 |
| dr_bus | input | 96 | Stored register values, pot p reg r at (p*4+r)*6 +: 6 |
| wip | input | 1 | Busy flag returned by the status read |
| sdo | output | 1 | Serial data to host, 0 while not enabled |
| sdo_en | output | 1 | Enable of the external tri-state driver for sdo |
| cmd_valid | output | 1 | One-cycle commit strobe |
| cmd_kind | output | 3 | Commit kind 1..6 |
| cmd_pot | output | 2 | Pot select of the commit |
| cmd_reg | output | 2 | Register select of the commit |
| cmd_data | output | 6 | Write value (0 for transfers) |
| step_valid | output | 1 | One-cycle wiper step pulse |
| step_up | output | 1 | Step direction, 1 = up |
| step_pot | output | 2 | Pot to step |

## Verification
Two actions can fall in the same system clock cycle: a final rising serial clock edge and the rise of chip select. The block lets chip select win and drops that edge. The bench provokes this by raising both inputs in the same cycle on the last bit of a wiper write, and it expects no commit. A second collision is a pause request arriving while the frame is mid-byte. The bench toggles the serial clock during the pause and then checks that the commit, or the readback byte, is identical to that of an uninterrupted frame.

// File: rtl/spipot_pkg.sv
package spipot_pkg;

    localparam int VAL_W  = 6;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 2;
    localparam int NPOT   = 1 << SEL_W;
    localparam int NREG   = 1 << SEL_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam int KIND_W = 3;

    localparam logic [3:0]        DEV_TYPE    = 4'b0101;
    localparam logic [BYTE_W-1:0] STATUS_BYTE = 8'b0101_0001;

    typedef enum logic [3:0] {
        OP_RD_WCR   = 4'b1001,
        OP_WR_WCR   = 4'b1010,
        OP_RD_DR    = 4'b1011,
        OP_WR_DR    = 4'b1100,
        OP_DR2WCR   = 4'b1101,
        OP_WCR2DR   = 4'b1110,
        OP_GDR2WCR  = 4'b0001,
        OP_GWCR2DR  = 4'b1000,
        OP_STEP     = 4'b0010,
        OP_STAT     = 4'b0101
    } opcode_e;

    typedef struct packed {
        opcode_e          op;
        logic [SEL_W-1:0] rsel;
        logic [SEL_W-1:0] psel;
    } instr_t;

    typedef enum logic [KIND_W-1:0] {
        K_NONE     = 3'd0,
        K_WR_WCR   = 3'd1,
        K_WR_DR    = 3'd2,
        K_DR2WCR   = 3'd3,
        K_WCR2DR   = 3'd4,
        K_GDR2WCR  = 3'd5,
        K_GWCR2DR  = 3'd6
    } cmd_kind_e;

    typedef enum logic [2:0] {
        F_IDLE, F_ID, F_INSTR, F_DATA_IN, F_DATA_OUT, F_DONE, F_STEP, F_DROP
    } frame_st_e;

    function automatic cmd_kind_e kind_of(opcode_e op);
        case (op)
            OP_WR_WCR:  return K_WR_WCR;
            OP_WR_DR:   return K_WR_DR;
            OP_DR2WCR:  return K_DR2WCR;
            OP_WCR2DR:  return K_WCR2DR;
            OP_GDR2WCR: return K_GDR2WCR;
            OP_GWCR2DR: return K_GWCR2DR;
            default:    return K_NONE;
        endcase
    endfunction

    function automatic logic is_nv(cmd_kind_e k);
        return (k == K_WR_DR) || (k == K_WCR2DR) || (k == K_GWCR2DR);
    endfunction

    function automatic logic is_write(cmd_kind_e k);
        return (k == K_WR_DR) || (k == K_WR_WCR);
    endfunction

    function automatic frame_st_e decode_next(logic [BYTE_W-1:0] b);
        instr_t ins;
        ins = instr_t'(b);
        case (ins.op)
            OP_RD_WCR, OP_RD_DR:                        return F_DATA_OUT;
            OP_STAT:    return (b == STATUS_BYTE) ? F_DATA_OUT : F_DROP;
            OP_WR_WCR, OP_WR_DR:                        return F_DATA_IN;
            OP_DR2WCR, OP_WCR2DR, OP_GDR2WCR, OP_GWCR2DR: return F_DONE;
            OP_STEP:                                    return F_STEP;
            default:                                    return F_DROP;
        endcase
    endfunction

endpackage

// File: rtl/spipot_edges.sv
module spipot_edges
    import spipot_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic hold_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic paused
);
    logic sck_q, cs_q, paused_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q    <= 1'b0;
            cs_q     <= 1'b0;   // treated as "was low": a fall needs a high first
            paused_q <= 1'b0;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
            if (cs_n)
                paused_q <= 1'b0;
            else if (!sck)
                paused_q <= !hold_n;  // pause state only moves while clock is low
        end
    end

    assign sck_rise = sck  & ~sck_q & ~paused_q & ~cs_n;
    assign sck_fall = ~sck & sck_q  & ~paused_q & ~cs_n;
    assign cs_fall  = ~cs_n & cs_q;
    assign paused   = paused_q;
endmodule

// File: rtl/spipot_frame.sv
module spipot_frame
    import spipot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sdi,
    input  logic              wp_n,
    input  logic [SEL_W-1:0]  strap,
    output frame_st_e         st,
    output instr_t            instr_q,
    output logic              rd_go,
    output logic              cmd_valid,
    output cmd_kind_e         cmd_kind,
    output logic [SEL_W-1:0]  cmd_pot,
    output logic [SEL_W-1:0]  cmd_reg,
    output logic [VAL_W-1:0]  cmd_data,
    output logic              step_valid,
    output logic              step_up
);
    logic [BYTE_W-2:0] rxsr;
    logic [BYTE_W-1:0] rx_next;
    logic [CNT_W-1:0]  bitcnt;
    logic [VAL_W-1:0]  data_q;
    logic              byte_done, id_ok;
    cmd_kind_e         pend_kind;
    frame_st_e         instr_next;

    assign rx_next    = {rxsr, sdi};
    assign byte_done  = sck_rise && (bitcnt == CNT_W'(BYTE_W-1));
    assign id_ok      = (rx_next[7:4] == DEV_TYPE) && (rx_next[3:2] == 2'b00)
                        && (rx_next[SEL_W-1:0] == strap);
    assign pend_kind  = kind_of(instr_q.op);
    assign instr_next = decode_next(rx_next);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= F_IDLE;
            bitcnt     <= '0;
            rxsr       <= '0;
            instr_q    <= '0;
            data_q     <= '0;
            rd_go      <= 1'b0;
            cmd_valid  <= 1'b0;
            cmd_kind   <= K_NONE;
            cmd_pot    <= '0;
            cmd_reg    <= '0;
            cmd_data   <= '0;
            step_valid <= 1'b0;
            step_up    <= 1'b0;
        end else begin
            rd_go      <= 1'b0;
            cmd_valid  <= 1'b0;
            step_valid <= 1'b0;
            if (cs_n) begin
                st     <= F_IDLE;
                bitcnt <= '0;
                if (st == F_DONE && !(is_nv(pend_kind) && !wp_n)) begin
                    cmd_valid <= 1'b1;
                    cmd_kind  <= pend_kind;
                    cmd_pot   <= instr_q.psel;
                    cmd_reg   <= instr_q.rsel;
                    cmd_data  <= is_write(pend_kind) ? data_q : '0;
                end
            end else if (cs_fall) begin
                st     <= F_ID;
                bitcnt <= '0;
            end else if (sck_rise) begin
                rxsr   <= rx_next[BYTE_W-2:0];
                bitcnt <= bitcnt + 1'b1;
                case (st)
                    F_ID:       if (byte_done) st <= id_ok ? F_INSTR : F_DROP;
                    F_INSTR:    if (byte_done) begin
                                    instr_q <= instr_t'(rx_next);
                                    st      <= instr_next;
                                    rd_go   <= (instr_next == F_DATA_OUT);
                                end
                    F_DATA_IN:  if (byte_done) begin
                                    data_q <= rx_next[VAL_W-1:0];
                                    st     <= F_DONE;
                                end
                    F_DATA_OUT: if (byte_done) st <= F_DROP;
                    F_DONE:     st <= F_DROP;   // surplus bit spoils the frame
                    F_STEP: begin
                        step_valid <= 1'b1;
                        step_up    <= sdi;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spipot_tx.sv
module spipot_tx
    import spipot_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        rd_go,
    input  instr_t                      instr,
    input  logic [NPOT*VAL_W-1:0]       wcr_bus,
    input  logic [NPOT*NREG*VAL_W-1:0]  dr_bus,
    input  logic                        wip,
    input  logic                        sck_fall,
    input  logic                        out_phase,
    input  logic                        cs_n,
    input  logic                        paused,
    output logic                        sdo,
    output logic                        sdo_en
);
    logic [VAL_W-1:0]  wcr_arr [NPOT];
    logic [VAL_W-1:0]  dr_arr  [NPOT*NREG];
    logic [BYTE_W-1:0] load_byte, txsr;
    logic              sdo_q;

    for (genvar p = 0; p < NPOT; p++) begin : g_wcr
        assign wcr_arr[p] = wcr_bus[p*VAL_W +: VAL_W];
    end
    for (genvar i = 0; i < NPOT*NREG; i++) begin : g_dr
        assign dr_arr[i] = dr_bus[i*VAL_W +: VAL_W];
    end

    always_comb begin
        case (instr.op)
            OP_RD_WCR: load_byte = {{(BYTE_W-VAL_W){1'b0}}, wcr_arr[instr.psel]};
            OP_RD_DR:  load_byte = {{(BYTE_W-VAL_W){1'b0}}, dr_arr[{instr.psel, instr.rsel}]};
            default:   load_byte = {{(BYTE_W-1){1'b0}}, wip};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txsr  <= '0;
            sdo_q <= 1'b0;
        end else if (rd_go) begin
            txsr <= load_byte;
        end else if (sck_fall && out_phase) begin
            sdo_q <= txsr[BYTE_W-1];
            txsr  <= {txsr[BYTE_W-2:0], 1'b0};
        end
    end

    assign sdo_en = out_phase & ~paused & ~cs_n;
    assign sdo    = sdo_en & sdo_q;
endmodule

// File: rtl/spipot_frontend.sv
module spipot_frontend
    import spipot_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cs_n,
    input  logic                        sck,
    input  logic                        sdi,
    input  logic                        hold_n,
    input  logic                        wp_n,
    input  logic [SEL_W-1:0]            strap,
    input  logic [NPOT*VAL_W-1:0]       wcr_bus,
    input  logic [NPOT*NREG*VAL_W-1:0]  dr_bus,
    input  logic                        wip,
    output logic                        sdo,
    output logic                        sdo_en,
    output logic                        cmd_valid,
    output logic [KIND_W-1:0]           cmd_kind,
    output logic [SEL_W-1:0]            cmd_pot,
    output logic [SEL_W-1:0]            cmd_reg,
    output logic [VAL_W-1:0]            cmd_data,
    output logic                        step_valid,
    output logic                        step_up,
    output logic [SEL_W-1:0]            step_pot
);
    logic      sck_rise, sck_fall, cs_fall, paused, rd_go;
    frame_st_e st;
    instr_t    instr_q;
    cmd_kind_e kind_e;

    spipot_edges u_edges (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .hold_n(hold_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .paused(paused)
    );

    spipot_frame u_frame (
        .clk(clk), .rst(rst), .cs_n(cs_n), .cs_fall(cs_fall), .sck_rise(sck_rise),
        .sdi(sdi), .wp_n(wp_n), .strap(strap), .st(st), .instr_q(instr_q),
        .rd_go(rd_go), .cmd_valid(cmd_valid), .cmd_kind(kind_e), .cmd_pot(cmd_pot),
        .cmd_reg(cmd_reg), .cmd_data(cmd_data), .step_valid(step_valid), .step_up(step_up)
    );

    spipot_tx u_tx (
        .clk(clk), .rst(rst), .rd_go(rd_go), .instr(instr_q), .wcr_bus(wcr_bus),
        .dr_bus(dr_bus), .wip(wip), .sck_fall(sck_fall), .out_phase(st == F_DATA_OUT),
        .cs_n(cs_n), .paused(paused), .sdo(sdo), .sdo_en(sdo_en)
    );

    assign cmd_kind = kind_e;
    assign step_pot = instr_q.psel;
endmodule

// File: rtl/spipot_frontend_chk.sv
module spipot_frontend_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       wp_n,
    input logic       paused,
    input logic       sdo_en,
    input logic       cmd_valid,
    input logic [2:0] cmd_kind,
    input logic       step_valid
);
    // R9: output driver off while deselected
    p_sdo_off_deselected_r9: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sdo_en);

    // R4: a commit only follows a cycle with chip select high
    p_commit_after_deselect_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(cs_n));

    // R3: one pulse per frame
    p_commit_single_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !cmd_valid);

    // R7: steps only while selected, never together with a commit
    p_step_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        step_valid |-> (!$past(cs_n) && !cmd_valid));

    // R12: protected kinds never reported with write protection low
    p_wp_guard_r12: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !$past(wp_n)) |-> (cmd_kind != 3'd2 && cmd_kind != 3'd4 && cmd_kind != 3'd6));

    // R8: a held pause produces no step and no output
    p_pause_silent_r8: assert property (@(posedge clk) disable iff (rst)
        (paused && $past(paused)) |-> (!step_valid && !sdo_en));
endmodule

bind spipot_frontend spipot_frontend_chk u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wp_n(wp_n), .paused(paused),
    .sdo_en(sdo_en), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .step_valid(step_valid)
);

// File: tb/test_spipot_frontend.sv
module test_spipot_frontend;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam logic [1:0] MY_STRAP = 2'b10;

    logic        clk = 1'b0;
    logic        rst, cs_n, sck, sdi, hold_n, wp_n, wip;
    logic [1:0]  strap;
    logic [23:0] wcr_bus;
    logic [95:0] dr_bus;
    logic        sdo, sdo_en, cmd_valid, step_valid, step_up;
    logic [2:0]  cmd_kind;
    logic [1:0]  cmd_pot, cmd_reg, step_pot;
    logic [5:0]  cmd_data;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";
    logic [14:0] exp_q [$];
    string       tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    spipot_frontend i_spipot_frontend (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .sdi(sdi), .hold_n(hold_n),
        .wp_n(wp_n), .strap(strap), .wcr_bus(wcr_bus), .dr_bus(dr_bus), .wip(wip),
        .sdo(sdo), .sdo_en(sdo_en), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_pot(cmd_pot), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
        .step_valid(step_valid), .step_up(step_up), .step_pot(step_pot)
    );

    function automatic logic [5:0] wcr_val(int p);
        return 6'(p * 11 + 3);
    endfunction
    function automatic logic [5:0] dr_val(int p, int r);
        return 6'(p * 16 + r * 5 + 7);
    endfunction
    function automatic logic [7:0] idb(logic [1:0] s);
        return {4'b0101, 2'b00, s};
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic expect_cmd(int kind, int pot, int rg, int data, string tag);
        exp_q.push_back({1'b1, 3'(kind), 2'(pot), 2'(rg), 6'(data), 1'b0});
        tag_q.push_back(tag);
    endtask
    task automatic expect_step(int pot, bit up, string tag);
        exp_q.push_back({1'b0, 3'd0, 2'(pot), 2'd0, 6'd0, up});
        tag_q.push_back(tag);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && (cmd_valid || step_valid)) begin
            logic [14:0] got;
            got = cmd_valid ? {1'b1, cmd_kind, cmd_pot, cmd_reg, cmd_data, 1'b0}
                            : {1'b0, 3'd0, step_pot, 2'd0, 6'd0, step_up};
            if (exp_q.size() == 0) begin
                check(1'b0, cur_tag, "unexpected event", int'(got), 0);
            end else begin
                logic [14:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, t, "event", int'(got), int'(e));
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic rb, output logic re);
        sdi = b;
        rb  = sdo;
        re  = sdo_en;
        wait_clk(HALF); sck = 1'b1;
        wait_clk(HALF); sck = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic xbyte(input logic [7:0] v, output logic [7:0] r, output logic en_all);
        logic rb, re;
        en_all = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            xbit(v[i], rb, re);
            r[i]   = rb;
            en_all = en_all & re;
        end
    endtask

    task automatic fbegin();
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask
    task automatic fend();
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic drained(string tag);
        check(exp_q.size() == 0, tag, "missing events", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nbytes,
                         input logic [7:0] b2);
        logic [7:0] r;
        logic en;
        fbegin();
        xbyte(b0, r, en);
        xbyte(b1, r, en);
        if (nbytes == 3) xbyte(b2, r, en);
        fend();
    endtask

    task automatic read_check(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] exp, input bit exp_en, string tag);
        logic [7:0] r;
        logic en;
        fbegin();
        xbyte(b0, r, en);
        xbyte(b1, r, en);
        xbyte(8'h00, r, en);
        fend();
        check(en == exp_en, tag, "sdo_en over data byte", int'(en), int'(exp_en));
        if (exp_en) check(r == exp, tag, "read byte", int'(r), int'(exp));
        drained(tag);
    endtask

    initial begin
        logic [7:0] r;
        logic rb, re, en;
        rst = 1'b1; cs_n = 1'b0; sck = 1'b0; sdi = 1'b0; hold_n = 1'b1;
        wp_n = 1'b1; wip = 1'b0; strap = MY_STRAP;
        for (int p = 0; p < 4; p++) begin
            wcr_bus[p*6 +: 6] = wcr_val(p);
            for (int q = 0; q < 4; q++) dr_bus[(p*4+q)*6 +: 6] = dr_val(p, q);
        end
        wait_clk(5);
        rst = 1'b0;
        wait_clk(1);
        // R9: reset state
        check(sdo_en == 1'b0, "R9", "sdo_en after reset", int'(sdo_en), 0);
        check(cmd_valid == 1'b0 && step_valid == 1'b0, "R9", "strobes after reset",
              int'({cmd_valid, step_valid}), 0);

        // R1: traffic with chip select low since reset is not framed
        cur_tag = "R1";
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b1010_00_01, r, en);
        xbyte(8'h15, r, en);
        fend();
        drained("R1");

        // R4: writes
        cur_tag = "R4";
        expect_cmd(1, 2, 0, 6'h2A, "R4");
        frame(idb(MY_STRAP), 8'b1010_00_10, 3, 8'h2A);
        drained("R4");
        expect_cmd(2, 1, 3, 6'h15, "R4");
        frame(idb(MY_STRAP), 8'b1100_11_01, 3, 8'h15);
        drained("R4");

        // R3: transfers
        cur_tag = "R3";
        expect_cmd(3, 3, 1, 0, "R3");
        frame(idb(MY_STRAP), 8'b1101_01_11, 2, 8'h00);
        expect_cmd(4, 0, 2, 0, "R3");
        frame(idb(MY_STRAP), 8'b1110_10_00, 2, 8'h00);
        expect_cmd(5, 0, 3, 0, "R3");
        frame(idb(MY_STRAP), 8'b0001_11_00, 2, 8'h00);
        expect_cmd(6, 0, 1, 0, "R3");
        frame(idb(MY_STRAP), 8'b1000_01_00, 2, 8'h00);
        drained("R3");

        // R2: identity mismatches
        cur_tag = "R2";
        frame(idb(2'b01), 8'b1010_00_10, 3, 8'h11);
        frame({4'b0111, 2'b00, MY_STRAP}, 8'b1101_00_00, 2, 8'h00);
        frame({4'b0101, 2'b01, MY_STRAP}, 8'b1101_00_00, 2, 8'h00);
        drained("R2");
        read_check(idb(2'b00), 8'b1001_00_01, 8'h00, 1'b0, "R2");

        // R5: reads
        cur_tag = "R5";
        read_check(idb(MY_STRAP), 8'b1001_00_01, {2'b00, wcr_val(1)}, 1'b1, "R5");
        read_check(idb(MY_STRAP), 8'b1011_01_10, {2'b00, dr_val(2, 1)}, 1'b1, "R5");
        read_check(idb(MY_STRAP), 8'b1011_11_11, {2'b00, dr_val(3, 3)}, 1'b1, "R5");

        // R6: status
        cur_tag = "R6";
        wip = 1'b1;
        read_check(idb(MY_STRAP), 8'b0101_0001, 8'h01, 1'b1, "R6");
        wip = 1'b0;
        read_check(idb(MY_STRAP), 8'b0101_0001, 8'h00, 1'b1, "R6");

        // R11: no-op opcodes
        cur_tag = "R11";
        read_check(idb(MY_STRAP), 8'b0101_0010, 8'h00, 1'b0, "R11");
        read_check(idb(MY_STRAP), 8'b0011_00_00, 8'h00, 1'b0, "R11");
        read_check(idb(MY_STRAP), 8'b0000_11_11, 8'h00, 1'b0, "R11");

        // R7: stepping
        cur_tag = "R7";
        expect_step(1, 1'b1, "R7");
        expect_step(1, 1'b1, "R7");
        expect_step(1, 1'b0, "R7");
        expect_step(1, 1'b1, "R7");
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b0010_00_01, r, en);
        xbit(1'b1, rb, re);
        xbit(1'b1, rb, re);
        xbit(1'b0, rb, re);
        xbit(1'b1, rb, re);
        fend();
        drained("R7");

        // R8: pause mid instruction byte during a stored write
        cur_tag = "R8";
        expect_cmd(2, 0, 0, 6'h33, "R8");
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        for (int i = 7; i >= 4; i--) xbit(1'(8'b1100_00_00 >> i), rb, re);
        hold_n = 1'b0; wait_clk(HALF);
        for (int k = 0; k < 3; k++) begin
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
        for (int i = 3; i >= 0; i--) xbit(1'(8'b1100_00_00 >> i), rb, re);
        xbyte(8'h33, r, en);
        fend();
        drained("R8");

        // R8: pause during a read
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b1001_00_11, r, en);
        for (int i = 7; i >= 5; i--) begin xbit(1'b0, rb, re); r[i] = rb; end
        hold_n = 1'b0; wait_clk(HALF);
        check(sdo_en == 1'b0, "R8", "sdo_en while paused", int'(sdo_en), 0);
        for (int k = 0; k < 2; k++) begin
            sck = 1'b1; wait_clk(HALF); sck = 1'b0; wait_clk(HALF);
        end
        hold_n = 1'b1; wait_clk(HALF);
        for (int i = 4; i >= 0; i--) begin xbit(1'b0, rb, re); r[i] = rb; end
        fend();
        check(r == {2'b00, wcr_val(3)}, "R8", "read after resume", int'(r),
              int'({2'b00, wcr_val(3)}));
        drained("R8");

        // R10: aborts
        cur_tag = "R10";
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b1010_00_00, r, en);
        for (int i = 0; i < 4; i++) xbit(1'b1, rb, re);
        fend();
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b1101_00_01, r, en);
        xbit(1'b0, rb, re);
        fend();
        fbegin();
        xbyte(idb(MY_STRAP), r, en);
        xbyte(8'b1010_00_00, r, en);
        for (int i = 0; i < 7; i++) xbit(1'b1, rb, re);
        sdi = 1'b1; wait_clk(HALF);
        sck = 1'b1; cs_n = 1'b1;
        wait_clk(HALF); sck = 1'b0;
        wait_clk(3 * HALF);
        check(sdo_en == 1'b0, "R9", "sdo_en deselected", int'(sdo_en), 0);
        drained("R10");

        // R12: write protection
        cur_tag = "R12";
        wp_n = 1'b0;
        frame(idb(MY_STRAP), 8'b1100_00_00, 3, 8'h3F);
        frame(idb(MY_STRAP), 8'b1000_10_00, 2, 8'h00);
        frame(idb(MY_STRAP), 8'b1110_01_10, 2, 8'h00);
        drained("R12");
        expect_cmd(1, 3, 0, 6'h07, "R12");
        frame(idb(MY_STRAP), 8'b1010_00_11, 3, 8'h07);
        expect_cmd(3, 2, 2, 0, "R12");
        frame(idb(MY_STRAP), 8'b1101_10_10, 2, 8'h00);
        drained("R12");
        wp_n = 1'b1;

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL %s watchdog expired: actual 1 expected 0", cur_tag);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule